// File: doc/BRIEF.md
# Mode-Switchable Triple Bus Voter

This block joins three replicated processor buses to three downstream memory/device lanes using a synchronous request/acknowledge handshake. A processor holds its request, together with write enable, address and write data, until it sees an acknowledge. Each downstream lane answers with an acknowledge and read data.

The block runs in one of three operating modes, which software can change at run time:

- **Vote mode.** A single downstream transfer is issued on lane 0. Its fields are the bitwise majority of the three processors' fields. The single response is returned to all three processors.
- **Broadcast mode.** Processor 0 alone drives lane 0, which talks to a non-replicated device. The response from that device is copied to all three processors.
- **Split mode.** The three lanes pass straight through, so the system behaves as three independent machines.

Vote mode reports any lack of unanimity on a completed transfer through a one-cycle pulse. The transfer still goes through with the voted value. A requested mode change is held pending until no processor is requesting, so no transfer ever straddles two modes.

Top module: `tmr_bus_voter`

## Requirements
- R1: After reset the block is in vote mode, no mode change is pending, and `disagree` is low.
- R2: In vote mode, the write enable, address and write data on lane 0 are the bitwise majority of the three processors. Each output bit is 1 exactly when at least two of the three input bits are 1.
- R3: In vote mode, `devReq[0]` is high exactly when at least two of the three `procReq` bits are high, and `devReq[1]` and `devReq[2]` stay low.
- R4: In vote and broadcast modes, every processor receives `devAck[0]` as its acknowledge and lane 0's read data as its read data. Acknowledges and read data on lanes 1 and 2 have no effect.
- R5: In broadcast mode, lane 0 carries processor 0's request, write enable, address and write data unchanged. The requests and fields of processors 1 and 2 have no effect on any downstream lane.
- R6: In split mode, lane i (for i = 0, 1, 2) connects processor i straight to downstream lane i in both directions.
- R7: In vote mode, consider a cycle in which `devReq[0]` and `devAck[0]` are both high and the three processors differ in any bit of request, write enable, address or write data. `disagree` is high for exactly the following cycle, and is low in every other case.
- R8: A mode write uses the encoding 00 = vote, 01 = broadcast, 10 = split. A write of 11 is ignored: the pending flag and the mode are left unchanged.
- R9: An accepted mode write raises `modePending`. The new mode takes effect at the clock edge that ends the first cycle in which the pending flag is set and all three `procReq` are low. While any request is high, the mode does not change. A write in the same cycle as an application becomes the next pending mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Mode write strobe |
| cfgMode | input | 2 | Requested mode (00 vote, 01 broadcast, 10 split) |
| procReq | input | 3 | Request from each processor |
| procWe | input | 3 | Write enable from each processor |
| procAddr | input | 3*AW | Address from each processor, lane i at bits [i*AW +: AW] |
| procWdata | input | 3*DW | Write data from each processor, lane i at bits [i*DW +: DW] |
| procAck | output | 3 | Acknowledge to each processor |
| procRdata | output | 3*DW | Read data to each processor |
| devReq | output | 3 | Request to each downstream lane |
| devWe | output | 3 | Write enable to each downstream lane |
| devAddr | output | 3*AW | Address to each downstream lane |
| devWdata | output | 3*DW | Write data to each downstream lane |
| devAck | input | 3 | Acknowledge from each downstream lane |
| devRdata | input | 3*DW | Read data from each downstream lane |
| modeNow | output | 2 | Mode in force |
| modePending | output | 1 | A mode change is waiting for the buses to go idle |
| disagree | output | 1 | One-cycle pulse after a non-unanimous voted transfer |

## Verification
Several properties are checked by assertions on every cycle:

- The mode never moves while a request is outstanding.
- The illegal mode code never appears.
- Each disagreement pulse traces back to a completed voted transfer.
- Outside split mode, the spare lanes stay silent and all three acknowledges agree.

Other behaviours can only be shown by the bench's scenarios against its reference model. These are the majority value of mixed bit patterns, the ignored mode code, and a pending change that waits out a busy stretch before applying. They also cover the routing of read data from lane 0 to every processor, and a long randomized mix of mode switches, disagreements and stray acknowledges.

// File: rtl/tmr_voter_pkg.sv
package tmr_voter_pkg;

  localparam int LANES = 3;

  typedef enum logic [1:0] {
    MODE_VOTE  = 2'b00,
    MODE_BCAST = 2'b01,
    MODE_SPLIT = 2'b10
  } busMode_e;

  // Decoded mode strobes handed from control to datapath (one-hot)
  typedef struct packed {
    logic vote;
    logic bcast;
    logic split;
  } laneCtl_t;

endpackage

// File: rtl/tmr_vote_path.sv
module tmr_vote_path
  import tmr_voter_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  laneCtl_t            ctl,
  input  logic [LANES-1:0]    procReq,
  input  logic [LANES-1:0]    procWe,
  input  logic [LANES*AW-1:0] procAddr,
  input  logic [LANES*DW-1:0] procWdata,
  output logic [LANES-1:0]    procAck,
  output logic [LANES*DW-1:0] procRdata,
  output logic [LANES-1:0]    devReq,
  output logic [LANES-1:0]    devWe,
  output logic [LANES*AW-1:0] devAddr,
  output logic [LANES*DW-1:0] devWdata,
  input  logic [LANES-1:0]    devAck,
  input  logic [LANES*DW-1:0] devRdata,
  output logic                beat,
  output logic                mismatch
);

  localparam int LW = 1 + AW + DW;

  logic [LW-1:0] laneWord [LANES];
  logic [LW-1:0] majWord;
  logic          reqQuorum;

  for (genvar i = 0; i < LANES; i++) begin : g_pack
    assign laneWord[i] = {procWe[i], procAddr[i*AW +: AW], procWdata[i*DW +: DW]};
  end

  // Bitwise two-of-three vote
  assign majWord   = (laneWord[0] & laneWord[1]) | (laneWord[0] & laneWord[2])
                   | (laneWord[1] & laneWord[2]);
  assign reqQuorum = (procReq[0] & procReq[1]) | (procReq[0] & procReq[2])
                   | (procReq[1] & procReq[2]);

  assign mismatch = (|(laneWord[0] ^ laneWord[1])) | (|(laneWord[0] ^ laneWord[2]))
                  | (procReq[0] ^ procReq[1]) | (procReq[0] ^ procReq[2]);
  assign beat     = ctl.vote & reqQuorum & devAck[0];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic          oReq;
    logic [LW-1:0] oWord;
    logic          oAck;
    logic [DW-1:0] oRdata;

    if (i == 0) begin : g_primary
      always_comb begin
        if (ctl.split) begin
          oReq  = procReq[0];
          oWord = laneWord[0];
        end else if (ctl.vote) begin
          oReq  = reqQuorum;
          oWord = majWord;
        end else begin
          oReq  = procReq[0];
          oWord = laneWord[0];
        end
      end
    end else begin : g_spare
      always_comb begin
        oReq  = ctl.split ? procReq[i]  : 1'b0;
        oWord = ctl.split ? laneWord[i] : '0;
      end
    end

    always_comb begin
      oAck   = ctl.split ? devAck[i] : devAck[0];
      oRdata = ctl.split ? devRdata[i*DW +: DW] : devRdata[0 +: DW];
    end

    assign devReq[i]             = oReq;
    assign devWe[i]              = oWord[LW-1];
    assign devAddr[i*AW +: AW]   = oWord[DW +: AW];
    assign devWdata[i*DW +: DW]  = oWord[DW-1:0];
    assign procAck[i]            = oAck;
    assign procRdata[i*DW +: DW] = oRdata;
  end

  // Spare lanes carry no request unless split
  p_spare_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.split |-> (devReq[2:1] == 2'b00));

  // One shared response outside split mode
  p_shared_ack_r4: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.split |-> (procAck == 3'b000 || procAck == 3'b111));

  // A voted request needs a quorum of processor requests
  p_quorum_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.vote && devReq[0]) |-> ($countones(procReq) >= 2));

endmodule

// File: rtl/tmr_vote_ctrl.sv
module tmr_vote_ctrl
  import tmr_voter_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [1:0]       cfgMode,
  input  logic [LANES-1:0] procReq,
  input  logic             beat,
  input  logic             mismatch,
  output laneCtl_t         ctl,
  output logic [1:0]       modeNow,
  output logic             modePending,
  output logic             disagree
);

  busMode_e modeQ, pendModeQ;
  logic     pendQ, disQ;
  logic     busIdle, cfgLegal;

  assign busIdle  = ~|procReq;
  assign cfgLegal = cfgWrEn && (cfgMode != 2'b11);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ     <= MODE_VOTE;
      pendModeQ <= MODE_VOTE;
      pendQ     <= 1'b0;
      disQ      <= 1'b0;
    end else begin
      if (pendQ && busIdle) begin
        modeQ <= pendModeQ;
        pendQ <= 1'b0;
      end
      if (cfgLegal) begin
        pendQ     <= 1'b1;
        pendModeQ <= busMode_e'(cfgMode);
      end
      disQ <= beat & mismatch;
    end
  end

  always_comb begin
    ctl       = '0;
    ctl.vote  = (modeQ == MODE_VOTE);
    ctl.bcast = (modeQ == MODE_BCAST);
    ctl.split = (modeQ == MODE_SPLIT);
  end

  assign modeNow     = modeQ;
  assign modePending = pendQ;
  assign disagree    = disQ;

  p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (|procReq) |=> $stable(modeQ));

  p_mode_from_pending_r9: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ != $past(modeQ)) |-> $past(pendQ));

  p_mode_legal_r8: assert property (@(posedge clk) disable iff (!rstN)
    modeQ != 2'b11);

  p_pulse_source_r7: assert property (@(posedge clk) disable iff (!rstN)
    disQ |-> $past(beat && mismatch));

endmodule

// File: rtl/tmr_bus_voter.sv
module tmr_bus_voter
  import tmr_voter_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cfgWrEn,
  input  logic [1:0]     cfgMode,
  input  logic [2:0]     procReq,
  input  logic [2:0]     procWe,
  input  logic [3*AW-1:0] procAddr,
  input  logic [3*DW-1:0] procWdata,
  output logic [2:0]     procAck,
  output logic [3*DW-1:0] procRdata,
  output logic [2:0]     devReq,
  output logic [2:0]     devWe,
  output logic [3*AW-1:0] devAddr,
  output logic [3*DW-1:0] devWdata,
  input  logic [2:0]     devAck,
  input  logic [3*DW-1:0] devRdata,
  output logic [1:0]     modeNow,
  output logic           modePending,
  output logic           disagree
);

  laneCtl_t ctl;
  logic     beat, mismatch;

  tmr_vote_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgMode(cfgMode),
    .procReq(procReq), .beat(beat), .mismatch(mismatch), .ctl(ctl),
    .modeNow(modeNow), .modePending(modePending), .disagree(disagree)
  );

  tmr_vote_path #(.AW(AW), .DW(DW)) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .procReq(procReq), .procWe(procWe), .procAddr(procAddr), .procWdata(procWdata),
    .procAck(procAck), .procRdata(procRdata),
    .devReq(devReq), .devWe(devWe), .devAddr(devAddr), .devWdata(devWdata),
    .devAck(devAck), .devRdata(devRdata), .beat(beat), .mismatch(mismatch)
  );

endmodule

// File: tb/tb_tmr_bus_voter.sv
module tb_tmr_bus_voter;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [1:0] cfgMode = 2'b00;
  logic [2:0] procReq = '0, procWe = '0, devAck = '0;
  logic [3*AW-1:0] procAddr = '0;
  logic [3*DW-1:0] procWdata = '0, devRdata = '0;
  logic [2:0] procAck, devReq, devWe;
  logic [3*DW-1:0] procRdata, devWdata;
  logic [3*AW-1:0] devAddr;
  logic [1:0] modeNow;
  logic modePending, disagree;

  int total = 0;
  int fails = 0;
  bit checkOn = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_bus_voter #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgMode(cfgMode),
    .procReq(procReq), .procWe(procWe), .procAddr(procAddr), .procWdata(procWdata),
    .procAck(procAck), .procRdata(procRdata), .devReq(devReq), .devWe(devWe),
    .devAddr(devAddr), .devWdata(devWdata), .devAck(devAck), .devRdata(devRdata),
    .modeNow(modeNow), .modePending(modePending), .disagree(disagree)
  );

  // ---------------- reference model ----------------
  int mMode = 0;        // 0 vote, 1 broadcast, 2 split
  bit mPend = 0;
  int mPendMode = 0;
  bit mDis = 0;

  logic [2:0] eReq, eWe, eAck;
  logic [3*AW-1:0] eAddr;
  logic [3*DW-1:0] eWdata, eRdata;
  bit eMismatch;

  function automatic logic [DW-1:0] vote32(logic [DW-1:0] a, logic [DW-1:0] b, logic [DW-1:0] c);
    logic [DW-1:0] r;
    for (int k = 0; k < DW; k++) begin
      int n;
      n = int'(a[k]) + int'(b[k]) + int'(c[k]);
      r[k] = (n >= 2);
    end
    return r;
  endfunction

  always @* begin
    int nReq;
    eReq = '0; eWe = '0; eAddr = '0; eWdata = '0;
    nReq = int'(procReq[0]) + int'(procReq[1]) + int'(procReq[2]);
    eMismatch = !(procReq[0] == procReq[1] && procReq[1] == procReq[2] &&
                  procWe[0] == procWe[1] && procWe[1] == procWe[2] &&
                  procAddr[0 +: AW] == procAddr[AW +: AW] && procAddr[AW +: AW] == procAddr[2*AW +: AW] &&
                  procWdata[0 +: DW] == procWdata[DW +: DW] && procWdata[DW +: DW] == procWdata[2*DW +: DW]);
    if (mMode == 2) begin
      eReq = procReq; eWe = procWe; eAddr = procAddr; eWdata = procWdata;
      eAck = devAck; eRdata = devRdata;
    end else begin
      eAck = {3{devAck[0]}};
      eRdata = {3{devRdata[0 +: DW]}};
      if (mMode == 0) begin
        eReq[0] = (nReq >= 2);
        eWe[0] = (int'(procWe[0]) + int'(procWe[1]) + int'(procWe[2])) >= 2;
        eAddr[0 +: AW] = AW'(vote32(DW'(procAddr[0 +: AW]), DW'(procAddr[AW +: AW]), DW'(procAddr[2*AW +: AW])));
        eWdata[0 +: DW] = vote32(procWdata[0 +: DW], procWdata[DW +: DW], procWdata[2*DW +: DW]);
      end else begin
        eReq[0] = procReq[0]; eWe[0] = procWe[0];
        eAddr[0 +: AW] = procAddr[0 +: AW]; eWdata[0 +: DW] = procWdata[0 +: DW];
      end
    end
  end

  always @(posedge clk) begin
    if (!rstN) begin
      mMode <= 0; mPend <= 0; mPendMode <= 0; mDis <= 0;
    end else begin
      mDis <= (mMode == 0) && eReq[0] && devAck[0] && eMismatch;
      if (mPend && procReq == 3'b000) begin
        mMode <= mPendMode; mPend <= 0;
      end
      if (cfgWrEn && cfgMode != 2'b11) begin
        mPend <= 1; mPendMode <= int'(cfgMode);
      end
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checkOn && rstN) begin
      string fTag, rTag;
      fTag = (mMode == 0) ? "R2" : (mMode == 1) ? "R5" : "R6";
      rTag = (mMode == 2) ? "R6" : "R4";
      chk((mMode == 0) ? "R3" : fTag, "devReq", 128'(devReq), 128'(eReq));
      chk(fTag, "devWe", 128'(devWe), 128'(eWe));
      chk(fTag, "devAddr", 128'(devAddr), 128'(eAddr));
      chk(fTag, "devWdata", 128'(devWdata), 128'(eWdata));
      chk(rTag, "procAck", 128'(procAck), 128'(eAck));
      chk(rTag, "procRdata", 128'(procRdata), 128'(eRdata));
      chk("R7", "disagree", 128'(disagree), 128'(mDis));
      chk("R9", "modeNow", 128'(modeNow), 128'(mMode));
      chk("R9", "modePending", 128'(modePending), 128'(mPend));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic setAll(logic [2:0] rq, logic [2:0] we, logic [AW-1:0] a0, logic [AW-1:0] a1,
                        logic [AW-1:0] a2, logic [DW-1:0] d0, logic [DW-1:0] d1, logic [DW-1:0] d2);
    procReq = rq; procWe = we;
    procAddr = {a2, a1, a0};
    procWdata = {d2, d1, d0};
  endtask

  task automatic writeMode(logic [1:0] m);
    cfgWrEn = 1'b1; cfgMode = m; tick(); cfgWrEn = 1'b0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    #2;
    // R1: reset state
    chk("R1", "modeNow", 128'(modeNow), 128'(0));
    chk("R1", "modePending", 128'(modePending), 128'(0));
    chk("R1", "disagree", 128'(disagree), 128'(0));
    tick();
    checkOn = 1'b1;

    // R2: mixed bit patterns vote to 0x0FF0
    setAll(3'b111, 3'b011, 16'h00F0, 16'h0F00, 16'h0FF0, 32'hA, 32'hA, 32'hA);
    devRdata = {32'h3333, 32'h2222, 32'h1111};
    devAck = 3'b110;
    #2;
    chk("R2", "voted addr", 128'(devAddr[0 +: AW]), 128'(16'h0FF0));
    chk("R2", "voted we", 128'(devWe[0]), 128'(1));
    chk("R4", "stray ack ignored", 128'(procAck), 128'(0));
    devAck = 3'b001;
    tick();
    #2;
    chk("R7", "pulse after mismatched beat", 128'(disagree), 128'(1));
    setAll(3'b000, 3'b000, 0, 0, 0, 0, 0, 0); devAck = 0;
    tick();
    #2;
    chk("R7", "pulse is one cycle", 128'(disagree), 128'(0));

    // R3: single request gives no downstream request
    setAll(3'b010, 3'b000, 1, 1, 1, 0, 0, 0);
    #2;
    chk("R3", "no quorum", 128'(devReq), 128'(0));
    tick();

    // R8: code 11 is ignored
    writeMode(2'b11);
    #2;
    chk("R8", "11 leaves pending clear", 128'(modePending), 128'(0));
    chk("R8", "11 leaves mode", 128'(modeNow), 128'(0));

    // R9: write split while busy; held until idle
    writeMode(2'b10);
    tick();
    #2;
    chk("R9", "held while busy", 128'(modeNow), 128'(0));
    chk("R9", "pending while busy", 128'(modePending), 128'(1));
    setAll(3'b000, 3'b000, 0, 0, 0, 0, 0, 0);
    tick();
    #2;
    chk("R9", "applied after idle", 128'(modeNow), 128'(2));

    // R6: split lanes pass straight
    setAll(3'b101, 3'b100, 16'h11, 16'h22, 16'h33, 32'h44, 32'h55, 32'h66);
    devAck = 3'b100;
    #2;
    chk("R6", "lane 2 addr", 128'(devAddr[2*AW +: AW]), 128'(16'h33));
    chk("R6", "lane 2 ack", 128'(procAck), 128'(3'b100));
    tick();
    setAll(0, 0, 0, 0, 0, 0, 0, 0); devAck = 0;

    // R5: broadcast from processor 0, response to all
    writeMode(2'b01);
    tick();
    setAll(3'b110, 3'b110, 16'h9, 16'h8, 16'h7, 32'h1, 32'h2, 32'h3);
    devAck = 3'b001;
    #2;
    chk("R5", "other processors ignored", 128'(devReq), 128'(0));
    chk("R4", "broadcast response", 128'(procAck), 128'(3'b111));
    tick();
    setAll(0, 0, 0, 0, 0, 0, 0, 0); devAck = 0;
    tick();

    // Randomized mix checked against the model on every cycle
    for (int c = 0; c < 4000; c++) begin
      logic [AW-1:0] ba; logic [DW-1:0] bd;
      logic [AW-1:0] a [3]; logic [DW-1:0] d [3];
      logic [2:0] we;
      ba = AW'($urandom); bd = $urandom;
      for (int i = 0; i < 3; i++) begin a[i] = ba; d[i] = bd; end
      we = {3{1'($urandom)}};
      if ($urandom_range(3) == 0) begin
        int l;
        l = $urandom_range(2);
        a[l] = a[l] ^ AW'($urandom);
        d[l] = d[l] ^ $urandom;
        we[l] = ~we[l];
      end
      setAll(($urandom_range(3) == 0) ? 3'b000 : 3'($urandom), we, a[0], a[1], a[2], d[0], d[1], d[2]);
      devAck = 3'($urandom);
      devRdata = {$urandom, $urandom, $urandom};
      cfgWrEn = ($urandom_range(15) == 0);
      cfgMode = 2'($urandom);
      tick();
    end
    cfgWrEn = 1'b0;
    tick();
    checkOn = 1'b0;
    finishRun();
  end

endmodule